// File: doc/BRIEF.md
# Register Pair File with Pointer Auto-Modify

This block keeps six 8-bit general registers, organised as three pairs (BC, DE, HL), and a 16-bit stack pointer (SP). A 3-bit select code picks one 16-bit pair. A pair value always has the first register of the pair as its upper byte and the second as its lower byte.

The block has four access paths:

- A combinational read port.
- A clocked write port.
- A memory-pointer port. It hands out an address and can post-increment or post-decrement HL in the same clock.
- A 16-bit adder. It adds a selected pair to HL, writes the sum back into HL and updates the subtract (N), half-carry (H) and carry (C) flags.

An execution unit drives these ports from its decoder. Every operation finishes in one clock. If an enabled port sees an undefined select code, that operation is dropped and a one-cycle error pulse is raised.

Top module: `regpair_file`

## Requirements
- R1: The read port returns BC for code 3'b001, DE for 3'b011, HL for 3'b101 and SP for 3'b111, combinationally. Each pair is {upper register, lower register}. An even (undefined) read code returns 16'h0000.
- R2: A write with a valid code stores wr_data[15:8] in the upper register and wr_data[7:0] in the lower register of the pair. Code 3'b111 loads SP as a single 16-bit value. The new value is visible on the read port after the clock edge.
- R3: On the pointer port, codes 3'b001 and 3'b011 return BC and DE and leave every register unchanged.
- R4: On the pointer port, code 3'b101 returns the current HL. At the clock edge HL becomes HL+1, so 16'hFFFF wraps to 16'h0000.
- R5: On the pointer port, code 3'b111 returns the current HL. At the clock edge HL becomes HL-1, so 16'h0000 wraps to 16'hFFFF.
- R6: An add with a valid code stores (HL + pair) mod 2^16 into HL. When the selected pair is HL, the operand is HL itself.
- R7: An add clears N. It sets H to the carry out of bit 11 of the sum of the low 12 bits of both operands. It sets C to the carry out of bit 15. In a cycle with no valid add, all three flags hold their value.
- R8: An enabled write, pointer or add port that carries an even code changes no register. It makes illegal_sel high in the following cycle only. illegal_sel is low after any cycle with no such access.
- R9: When more than one operation targets HL in the same cycle, the pointer modify wins over the add, and the add wins over the write. Writes to other pairs in that cycle still take effect.
- R10: After reset all registers and SP read 16'h0000, flag_n reads 1, flag_h and flag_c read 0, and illegal_sel reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_sel | input | 3 | Read port pair select |
| rd_data | output | 16 | Selected pair value |
| wr_en | input | 1 | Write port enable |
| wr_sel | input | 3 | Write port pair select |
| wr_data | input | 16 | Value to write |
| ptr_en | input | 1 | Pointer port enable |
| ptr_sel | input | 3 | Pointer port select (with auto-modify for HL) |
| ptr_addr | output | 16 | Address returned by the pointer port |
| add_en | input | 1 | 16-bit add enable |
| add_sel | input | 3 | Pair to add to HL |
| flag_n | output | 1 | Subtract flag |
| flag_h | output | 1 | Half-carry flag (bit 11) |
| flag_c | output | 1 | Carry flag (bit 15) |
| illegal_sel | output | 1 | One-cycle pulse after an undefined select code |

## Verification
The bound assertions check four rules on every cycle. Pointer post-increment and post-decrement must match the address the port returned. N must be cleared after each add, and the flags must hold when no add occurs. The error pulse must follow an undefined code exactly, and a rejected or non-modifying access must leave the register contents unchanged. Some behaviour is only shown by the bench scenarios, where a behavioural model is compared against the outputs every cycle: the exact half-carry and carry values at the bit-11 and bit-15 boundaries, wrap-around of HL, the HL priority order when several operations collide, and correct byte placement within each pair.

// File: rtl/regpair_file.sv
module regpair_file #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      rd_sel,
  output logic [2*DW-1:0] rd_data,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [2*DW-1:0] wr_data,
  input  logic            ptr_en,
  input  logic [2:0]      ptr_sel,
  output logic [2*DW-1:0] ptr_addr,
  input  logic            add_en,
  input  logic [2:0]      add_sel,
  output logic            flag_n,
  output logic            flag_h,
  output logic            flag_c,
  output logic            illegal_sel
);
  localparam int PW = 2 * DW;
  localparam int HW = PW - 4;

  localparam logic [2:0] SEL_BC = 3'b001;
  localparam logic [2:0] SEL_DE = 3'b011;
  localparam logic [2:0] SEL_HL = 3'b101;
  localparam logic [2:0] SEL_SP = 3'b111;

  logic [DW-1:0] b_q, c_q, d_q, e_q, h_q, l_q;
  logic [PW-1:0] sp_q;
  logic [PW-1:0] bc, de, hl;

  assign bc = {b_q, c_q};
  assign de = {d_q, e_q};
  assign hl = {h_q, l_q};

  function automatic logic [PW-1:0] pick(input logic [2:0] sel,
                                         input logic [PW-1:0] p_bc,
                                         input logic [PW-1:0] p_de,
                                         input logic [PW-1:0] p_hl,
                                         input logic [PW-1:0] p_sp);
    case (sel)
      SEL_BC:  pick = p_bc;
      SEL_DE:  pick = p_de;
      SEL_HL:  pick = p_hl;
      SEL_SP:  pick = p_sp;
      default: pick = '0;
    endcase
  endfunction

  assign rd_data = pick(rd_sel, bc, de, hl, sp_q);

  always_comb begin
    case (ptr_sel)
      SEL_BC:         ptr_addr = bc;
      SEL_DE:         ptr_addr = de;
      SEL_HL, SEL_SP: ptr_addr = hl;
      default:        ptr_addr = '0;
    endcase
  end

  logic wr_ok, ptr_ok, add_ok, bad_sel;
  assign wr_ok   = wr_en  & wr_sel[0];
  assign ptr_ok  = ptr_en & ptr_sel[0];
  assign add_ok  = add_en & add_sel[0];
  assign bad_sel = (wr_en & ~wr_sel[0]) | (ptr_en & ~ptr_sel[0]) | (add_en & ~add_sel[0]);

  logic [PW-1:0] addend;
  logic [PW:0]   sum;
  logic [HW:0]   half_sum;
  assign addend   = pick(add_sel, bc, de, hl, sp_q);
  assign sum      = {1'b0, hl} + {1'b0, addend};
  assign half_sum = {1'b0, hl[HW-1:0]} + {1'b0, addend[HW-1:0]};

  logic [PW-1:0] hl_nx;
  always_comb begin
    hl_nx = hl;
    if (wr_ok && wr_sel == SEL_HL) hl_nx = wr_data;
    if (add_ok)                    hl_nx = sum[PW-1:0];
    if (ptr_ok && ptr_sel == SEL_HL) hl_nx = hl + 1'b1;
    else if (ptr_ok && ptr_sel == SEL_SP) hl_nx = hl - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0; c_q <= '0; d_q <= '0; e_q <= '0; h_q <= '0; l_q <= '0;
      sp_q <= '0;
      flag_n <= 1'b1;
      flag_h <= 1'b0;
      flag_c <= 1'b0;
      illegal_sel <= 1'b0;
    end else begin
      if (wr_ok && wr_sel == SEL_BC) {b_q, c_q} <= wr_data;
      if (wr_ok && wr_sel == SEL_DE) {d_q, e_q} <= wr_data;
      if (wr_ok && wr_sel == SEL_SP) sp_q <= wr_data;
      {h_q, l_q} <= hl_nx;
      if (add_ok) begin
        flag_n <= 1'b0;
        flag_h <= half_sum[HW];
        flag_c <= sum[PW];
      end
      illegal_sel <= bad_sel;
    end
  end
endmodule

// File: rtl/regpair_file_chk.sv
module regpair_file_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    rd_sel,
  input logic [PW-1:0] rd_data,
  input logic          wr_en,
  input logic [2:0]    wr_sel,
  input logic          ptr_en,
  input logic [2:0]    ptr_sel,
  input logic [PW-1:0] ptr_addr,
  input logic          add_en,
  input logic [2:0]    add_sel,
  input logic          flag_n,
  input logic          flag_h,
  input logic          flag_c,
  input logic          illegal_sel,
  input logic [PW-1:0] bc,
  input logic [PW-1:0] de,
  input logic [PW-1:0] hl,
  input logic [PW-1:0] sp_q
);
  logic any_bad, add_ok;
  assign any_bad = (wr_en & ~wr_sel[0]) | (ptr_en & ~ptr_sel[0]) | (add_en & ~add_sel[0]);
  assign add_ok  = add_en & add_sel[0];

  p_rd_undef_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel[0] |-> rd_data == '0);

  p_ptr_nomod_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_en && (ptr_sel == 3'b001 || ptr_sel == 3'b011) && !wr_en && !add_en
    |=> $stable(bc) && $stable(de) && $stable(hl) && $stable(sp_q));

  p_ptr_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_en && ptr_sel == 3'b101 |=> hl == PW'($past(ptr_addr) + 1'b1));

  p_ptr_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_en && ptr_sel == 3'b111 |=> hl == PW'($past(ptr_addr) - 1'b1));

  p_add_nclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    add_ok |=> !flag_n);

  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !add_ok |=> $stable(flag_n) && $stable(flag_h) && $stable(flag_c));

  p_ill_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_bad |=> illegal_sel);

  p_ill_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_bad |=> !illegal_sel);

  p_ill_nochg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel[0] && !ptr_en && !add_en
    |=> $stable(bc) && $stable(de) && $stable(hl) && $stable(sp_q));
endmodule

bind regpair_file regpair_file_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .rd_data(rd_data),
  .wr_en(wr_en), .wr_sel(wr_sel), .ptr_en(ptr_en), .ptr_sel(ptr_sel),
  .ptr_addr(ptr_addr), .add_en(add_en), .add_sel(add_sel),
  .flag_n(flag_n), .flag_h(flag_h), .flag_c(flag_c), .illegal_sel(illegal_sel),
  .bc(bc), .de(de), .hl(hl), .sp_q(sp_q)
);

// File: tb/regpair_file_tb.sv
`timescale 1ns/1ps
module regpair_file_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        ptr_en = 1'b0;
  logic [2:0]  ptr_sel = '0;
  logic [15:0] ptr_addr;
  logic        add_en = 1'b0;
  logic [2:0]  add_sel = '0;
  logic        flag_n, flag_h, flag_c, illegal_sel;

  always #4 clk = ~clk;

  regpair_file u_dut (
    .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .rd_data(rd_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ptr_en(ptr_en), .ptr_sel(ptr_sel), .ptr_addr(ptr_addr),
    .add_en(add_en), .add_sel(add_sel),
    .flag_n(flag_n), .flag_h(flag_h), .flag_c(flag_c), .illegal_sel(illegal_sel)
  );

  int m_bc, m_de, m_hl, m_sp;
  int m_n, m_h, m_c, m_ill;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic int pair_of(input int sel, input int bc, input int de,
                                 input int hl, input int sp);
    case (sel)
      1: return bc;
      3: return de;
      5: return hl;
      7: return sp;
      default: return 0;
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag,
                      input bit w_en, input int w_sel, input int w_d,
                      input bit p_en, input int p_sel,
                      input bit a_en, input int a_sel, input int r_sel);
    int exp_ptr, addend, sum, nhl;
    bit bad;
    @(negedge clk);
    wr_en = w_en; wr_sel = 3'(w_sel); wr_data = 16'(w_d);
    ptr_en = p_en; ptr_sel = 3'(p_sel);
    add_en = a_en; add_sel = 3'(a_sel);
    rd_sel = 3'(r_sel);
    #1;
    cmp(tag, "rd_data (R1)", int'(rd_data), pair_of(r_sel, m_bc, m_de, m_hl, m_sp));
    case (p_sel)
      1: exp_ptr = m_bc;
      3: exp_ptr = m_de;
      5, 7: exp_ptr = m_hl;
      default: exp_ptr = 0;
    endcase
    cmp(tag, "ptr_addr (R3/R4/R5)", int'(ptr_addr), exp_ptr);
    cmp(tag, "flags N,H,C (R7)", int'({flag_n, flag_h, flag_c}), m_n * 4 + m_h * 2 + m_c);
    cmp(tag, "illegal_sel (R8)", int'(illegal_sel), m_ill);
    @(posedge clk);
    #1;
    bad = (w_en && (w_sel % 2 == 0)) || (p_en && (p_sel % 2 == 0)) || (a_en && (a_sel % 2 == 0));
    addend = pair_of(a_sel, m_bc, m_de, m_hl, m_sp);
    nhl = m_hl;
    if (w_en && (w_sel % 2 == 1)) begin
      case (w_sel)
        1: m_bc = w_d & 'hffff;
        3: m_de = w_d & 'hffff;
        5: nhl  = w_d & 'hffff;
        default: m_sp = w_d & 'hffff;
      endcase
    end
    if (a_en && (a_sel % 2 == 1)) begin
      sum = m_hl + addend;
      m_n = 0;
      m_h = (((m_hl & 'hfff) + (addend & 'hfff)) > 'hfff) ? 1 : 0;
      m_c = (sum > 'hffff) ? 1 : 0;
      nhl = sum & 'hffff;
    end
    if (p_en && p_sel == 5) nhl = (m_hl + 1) & 'hffff;
    if (p_en && p_sel == 7) nhl = (m_hl + 'hffff) & 'hffff;
    m_hl = nhl;
    m_ill = bad ? 1 : 0;
  endtask

  task automatic wr(input string tag, input int sel, input int d);
    step(tag, 1, sel, d, 0, 0, 0, 0, sel);
  endtask

  task automatic rd(input string tag, input int sel);
    step(tag, 0, 0, 0, 0, 0, 0, 0, sel);
  endtask

  task automatic ptr(input string tag, input int sel);
    step(tag, 0, 0, 0, 1, sel, 0, 0, 5);
  endtask

  task automatic addp(input string tag, input int sel);
    step(tag, 0, 0, 0, 0, 0, 1, sel, 5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_bc = 0; m_de = 0; m_hl = 0; m_sp = 0;
    m_n = 1; m_h = 0; m_c = 0; m_ill = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    rd("R10", 1); rd("R10", 3); rd("R10", 5); rd("R10", 7);

    // R2 byte placement and SP whole load
    wr("R2", 1, 'h1234); wr("R2", 3, 'habcd); wr("R2", 5, 'h00ff); wr("R2", 7, 'hfffe);
    rd("R2", 1); rd("R2", 3); rd("R2", 5); rd("R2", 7);

    // R1 undefined read codes
    rd("R1", 0); rd("R1", 2); rd("R1", 4); rd("R1", 6);

    // R3 BC/DE pointer without modify
    ptr("R3", 1); ptr("R3", 3); rd("R3", 1); rd("R3", 3);

    // R4 post-increment with wrap
    wr("R4", 5, 'hfffe); ptr("R4", 5); ptr("R4", 5); rd("R4", 5);

    // R5 post-decrement with wrap
    ptr("R5", 7); ptr("R5", 7); rd("R5", 5);

    // R6/R7 add and flags at bit 11 / bit 15 boundaries
    wr("R6", 5, 'h0fff); wr("R6", 1, 'h0001); addp("R7", 1); rd("R7", 5);
    wr("R6", 5, 'hffff); wr("R6", 3, 'h0001); addp("R7", 3); rd("R7", 5);
    wr("R6", 5, 'h8000); addp("R6", 5); rd("R6", 5);
    wr("R6", 5, 'h0800); addp("R7", 5); rd("R7", 5);
    wr("R6", 5, 'h1234); wr("R6", 7, 'h0111); addp("R6", 7); rd("R7", 5);

    // R8 undefined codes on enabled ports
    step("R8", 1, 4, 'hdead, 0, 0, 0, 0, 5);
    rd("R8", 5);
    step("R8", 0, 0, 0, 1, 6, 0, 0, 5);
    step("R8", 0, 0, 0, 0, 0, 1, 2, 5);
    rd("R8", 5);
    step("R8", 1, 0, 'hbeef, 1, 2, 1, 4, 1);
    rd("R8", 1); rd("R8", 7);

    // R9 HL priority
    wr("R9", 5, 'h1000);
    step("R9", 1, 5, 'h5555, 1, 5, 0, 0, 5);
    rd("R9", 5);
    step("R9", 0, 0, 0, 1, 7, 1, 1, 5);
    rd("R9", 5);
    step("R9", 1, 5, 'h7777, 0, 0, 1, 3, 5);
    rd("R9", 5);
    step("R9", 1, 1, 'h4321, 1, 5, 1, 1, 1);
    rd("R9", 1); rd("R9", 5);

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      bit we, pe, ae;
      we = ($urandom % 3) == 0;
      pe = ($urandom % 3) == 0;
      ae = ($urandom % 3) == 0;
      step("R9", we, int'($urandom % 8), int'($urandom % 65536),
           pe, int'($urandom % 8), ae, int'($urandom % 8), int'($urandom % 8));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule